// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with APB Access

This block is a peripheral timer sitting behind an APB slave port. A 16-bit counter steps down by one on every tick of a programmable clock divider. Software chooses the divider through a 3-bit code, picks between a wrapping mode and a reloading mode, and starts or stops the count with an enable bit.

In the reloading mode, a tick that finds the counter at zero does two things. It copies the programmed load value back into the counter and it sets a sticky interrupt flag. The interrupt request output follows that flag until software clears it. In the wrapping mode the counter rolls from zero to all ones and no interrupt is raised.

The register map puts each register on a 4-byte word:

| Offset | Register | Access | Use |
|---|---|---|---|
| 0x00 | LOAD | read/write | Reload value |
| 0x04 | COUNT | read-only | Current count |
| 0x08 | CTRL | read/write | Control fields |
| 0x0C | STATUS | read-only | Interrupt flag in bit 0 |
| 0x10 | CLEAR | write-only | Write 1 in bit 0 to clear the flag |

The CTRL register places the divide code in bits 4:2, the mode bit in bit 6 (1 selects reload) and the enable bit in bit 7.

Top module: `apb_downcount_timer`

## Requirements
- R1: After reset, LOAD, COUNT, CTRL and STATUS all read 0 and `irq` is low.
- R2: The divide code in CTRL bits 4:2 selects the tick ratio: code 0 gives 1, code 1 gives 16, code 2 gives 256, code 3 gives 2, code 4 gives 8, code 5 gives 32, code 6 gives 128, and code 7 gives 1024 clock cycles per tick.
- R3: While enabled, each tick lowers COUNT by one when COUNT is not zero.
- R4: With the mode bit (CTRL bit 6) at 0, a tick at COUNT zero sets COUNT to 0xFFFF and leaves the interrupt flag unchanged.
- R5: With the mode bit at 1, a tick at COUNT zero loads COUNT from LOAD and sets the interrupt flag. A full period is therefore (LOAD+1) times the ratio.
- R6: A write to LOAD while disabled also sets COUNT to the written value. A write to LOAD while enabled leaves COUNT untouched.
- R7: While CTRL bit 7 is 0, COUNT and the divider hold their values and the flag is not set.
- R8: A CTRL write that sets the enable bit while the timer is disabled restarts the divider. The first decrement then lands exactly one ratio of cycles after that write's access edge.
- R9: The interrupt flag is sticky. Writing 1 to bit 0 of CLEAR (0x10) clears it, but a set in the same cycle wins. `irq` always equals the flag, and STATUS bit 0 reads it.
- R10: Every transfer completes with no wait state and no error. Reads from offsets 0x14 to 0x1C return 0, and CTRL reads back only bits 7, 6 and 4:2.
- R11: With LOAD at 0 in reload mode, the flag is set on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and timer clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 5 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| irq | output | 1 | Interrupt request, equal to the sticky flag |

## Verification
The bench uses the default parameters: a 16-bit counter, a 5-bit address and a 32-bit data bus. With small load values, every divide ratio up to 1024 gives periods of a few thousand cycles. That lets all eight codes have their first-interrupt time measured exactly. The same short loads put the zero-crossing in both modes, and the load-of-zero case, within a few hundred cycles.

// File: rtl/tmr_pkg.sv
// Package: shared constants, control record and the divide-code table for
// the down-counting timer. Assumes a 10-bit divider is enough for ratio 1024.
package tmr_pkg;
    localparam int CODE_W     = 3;
    localparam int PRE_W      = 10;
    localparam int EN_BIT     = 7;
    localparam int MODE_BIT   = 6;
    localparam int CODE_LSB   = 2;

    localparam logic [2:0] IDX_LOAD  = 3'd0;
    localparam logic [2:0] IDX_COUNT = 3'd1;
    localparam logic [2:0] IDX_CTRL  = 3'd2;
    localparam logic [2:0] IDX_STAT  = 3'd3;
    localparam logic [2:0] IDX_CLR   = 3'd4;

    typedef struct packed {
        logic              en;
        logic              periodic;
        logic [CODE_W-1:0] code;
    } tmr_ctrl_t;

    // Terminal divider value (ratio - 1) for each code; order is not monotonic.
    function automatic logic [PRE_W-1:0] div_last(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    div_last = PRE_W'(0);
            3'd1:    div_last = PRE_W'(15);
            3'd2:    div_last = PRE_W'(255);
            3'd3:    div_last = PRE_W'(1);
            3'd4:    div_last = PRE_W'(7);
            3'd5:    div_last = PRE_W'(31);
            3'd6:    div_last = PRE_W'(127);
            default: div_last = PRE_W'(1023);
        endcase
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
// Module: clock divider producing a one-cycle tick every ratio cycles while
// enabled. Assumes restart only arrives while disabled; holds when disabled.
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] last;

    // Tick when the divider has reached the terminal value of the chosen code.
    always_comb begin
        last = div_last(code);
        tick = en && (pre_cnt >= last);
    end

    // Divider state: cleared on restart or tick, counts up only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_cnt <= '0;
        else if (restart) pre_cnt <= '0;
        else if (tick)    pre_cnt <= '0;
        else if (en)      pre_cnt <= pre_cnt + 1'b1;
    end

    p_tick_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en);
    p_hold_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !restart) |=> $stable(pre_cnt));
    p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_cnt == '0));
endmodule

// File: rtl/tmr_counter.sv
// Module: the down counter and the sticky interrupt flag. Assumes tick is
// only asserted while enabled; load_wr carries the new LOAD value.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             periodic,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_wdata,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    logic at_zero;
    logic hit;

    // Zero detection and the reload event that raises the flag.
    always_comb begin
        at_zero = (count == '0);
        hit     = tick && at_zero && periodic;
    end

    // Counter update: tick decrements, wraps or reloads; idle load write copies.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (tick && at_zero)  count <= periodic ? load_val : '1;
        else if (tick)             count <= count - 1'b1;
        else if (load_wr && !en)   count <= load_wdata;
    end

    // Sticky flag: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !at_zero) |=> (count == $past(count) - 1'b1));
    p_free_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_zero && !periodic) |=> (&count));
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_zero && periodic) |=> (count == $past(load_val)) && flag);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    p_no_set_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !flag) |=> !flag);
endmodule

// File: rtl/tmr_apb_regs.sv
// Module: APB register file and read mux for the timer. Assumes zero-wait
// transfers; decodes word index paddr[ADDR_W-1:2]; unmapped reads give 0.
module tmr_apb_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              flag,
    output logic [DATA_W-1:0] prdata,
    output tmr_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  load_val,
    output logic              load_wr,
    output logic [CNT_W-1:0]  load_wdata,
    output logic              restart,
    output logic              clr
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             wr;
    logic             unused_bits;

    // Write strobes and decoded side effects for the counter and divider.
    always_comb begin
        idx        = paddr[ADDR_W-1:2];
        wr         = psel && penable && pwrite;
        load_wr    = wr && (idx == IDX_W'(IDX_LOAD));
        load_wdata = pwdata[CNT_W-1:0];
        restart    = wr && (idx == IDX_W'(IDX_CTRL)) && pwdata[EN_BIT] && !ctrl.en;
        clr        = wr && (idx == IDX_W'(IDX_CLR)) && pwdata[0];
    end

    assign unused_bits = ^{pwdata, paddr[1:0]};

    // LOAD and CTRL storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_val <= '0;
            ctrl     <= '0;
        end else if (wr) begin
            if (idx == IDX_W'(IDX_LOAD)) load_val <= pwdata[CNT_W-1:0];
            if (idx == IDX_W'(IDX_CTRL)) begin
                ctrl.en       <= pwdata[EN_BIT];
                ctrl.periodic <= pwdata[MODE_BIT];
                ctrl.code     <= pwdata[CODE_LSB +: CODE_W];
            end
        end
    end

    // Read mux, driven only during read transfers.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (idx)
                IDX_W'(IDX_LOAD):  prdata = DATA_W'(load_val);
                IDX_W'(IDX_COUNT): prdata = DATA_W'(count);
                IDX_W'(IDX_CTRL): begin
                    prdata[EN_BIT]              = ctrl.en;
                    prdata[MODE_BIT]            = ctrl.periodic;
                    prdata[CODE_LSB +: CODE_W]  = ctrl.code;
                end
                IDX_W'(IDX_STAT):  prdata[0] = flag;
                default:           prdata = '0;
            endcase
        end
    end

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && (idx > IDX_W'(IDX_CLR))) |-> (prdata == '0));
    p_restart_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> ctrl.en);
endmodule

// File: rtl/apb_downcount_timer.sv
// Module: top of the prescaled down-counting timer. Wires the register file,
// divider and counter; APB transfers never stall and never error.
module apb_downcount_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq
);
    tmr_ctrl_t        ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] load_wdata;
    logic [CNT_W-1:0] count;
    logic             load_wr;
    logic             restart;
    logic             clr;
    logic             tick;
    logic             flag;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq     = flag;

    tmr_apb_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .count(count),
        .flag(flag), .prdata(prdata), .ctrl(ctrl), .load_val(load_val),
        .load_wr(load_wr), .load_wdata(load_wdata), .restart(restart), .clr(clr)
    );

    tmr_prescaler u_pre (
        .clk(pclk), .rst_n(presetn), .en(ctrl.en), .restart(restart),
        .code(ctrl.code), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(pclk), .rst_n(presetn), .en(ctrl.en), .periodic(ctrl.periodic),
        .tick(tick), .load_val(load_val), .load_wr(load_wr),
        .load_wdata(load_wdata), .clr(clr), .count(count), .flag(flag)
    );
endmodule

// File: tb/sim_apb_downcount_timer.sv
module sim_apb_downcount_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq;

    int checks = 0, fails = 0, cyc = 0;
    int m_load, m_cnt, m_ctrl, m_pre;
    bit m_flag;
    bit done = 0;

    always #10 clk = ~clk;

    apb_downcount_timer u0 (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq(irq)
    );

    function automatic int ratio_of(input int code);
        case (code)
            0: return 1;    1: return 16;  2: return 256; 3: return 2;
            4: return 8;    5: return 32;  6: return 128; default: return 1024;
        endcase
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural reference model, evaluated on pre-edge values.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_load = 0; m_cnt = 0; m_ctrl = 0; m_pre = 0; m_flag = 0;
        end else begin
            bit en_o, per_o, tk, acc, hit;
            int idx, cnt_o;
            en_o  = m_ctrl[7];
            per_o = m_ctrl[6];
            tk    = en_o && (m_pre >= ratio_of((m_ctrl >> 2) & 7) - 1);
            acc   = psel && penable && pwrite;
            idx   = int'(paddr) >> 2;
            cnt_o = m_cnt;
            hit   = tk && cnt_o == 0 && per_o;
            if (tk) begin
                m_pre = 0;
                if (cnt_o == 0) m_cnt = per_o ? m_load : 65535;
                else            m_cnt = cnt_o - 1;
            end else begin
                if (en_o) m_pre++;
                if (acc && idx == 0 && !en_o) m_cnt = int'(pwdata[15:0]);
            end
            if (hit) m_flag = 1;
            else if (acc && idx == 4 && pwdata[0]) m_flag = 0;
            if (acc && idx == 0) m_load = int'(pwdata[15:0]);
            if (acc && idx == 2) begin
                if (pwdata[7] && !en_o) m_pre = 0;
                m_ctrl = int'(pwdata) & 'hDC;
            end
        end
    end

    // Per-clock comparison of interrupt and handshake outputs against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 irq vs model", irq, m_flag);
            chk("R10 pready/pslverr", {pready, pslverr}, 2'b10);
        end
    end

    function automatic int model_read(input int a);
        case (a >> 2)
            0: return m_load;
            1: return m_cnt;
            2: return m_ctrl;
            3: return int'(m_flag);
            default: return 0;
        endcase
    endfunction

    task automatic apb_wr(input logic [4:0] a, input logic [31:0] d, output int edge_cyc);
        @(negedge clk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        edge_cyc = cyc;
    endtask

    task automatic apb_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk);
        penable = 1;
        d = prdata;
        chk("R3 read vs model", d, model_read(int'(a)));
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d, d2;
        int t0, t1;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R1: reset values
        apb_rd(5'h00, d); chk("R1 load after reset", d, 0);
        apb_rd(5'h04, d); chk("R1 count after reset", d, 0);
        apb_rd(5'h08, d); chk("R1 ctrl after reset", d, 0);
        apb_rd(5'h0C, d); chk("R1 status after reset", d, 0);
        chk("R1 irq after reset", irq, 0);

        // R10: unmapped reads and ctrl readback mask
        apb_rd(5'h14, d); chk("R10 unmapped 0x14", d, 0);
        apb_rd(5'h1C, d); chk("R10 unmapped 0x1C", d, 0);
        apb_wr(5'h08, 32'hFFFF_FF23, t0);
        apb_rd(5'h08, d); chk("R10 ctrl readback mask", d, 32'h0000_0000);
        apb_wr(5'h08, 32'h0000_005C, t0);
        apb_rd(5'h08, d); chk("R10 ctrl readback bits", d, 32'h5C);
        apb_wr(5'h08, 32'h0, t0);

        // R2, R5, R8: first interrupt after (load+1)*ratio for every code
        for (int c = 0; c < 8; c++) begin
            apb_wr(5'h08, 32'h0, t0);
            apb_wr(5'h10, 32'h1, t0);
            apb_wr(5'h00, 32'd2, t0);
            apb_rd(5'h04, d); chk("R6 idle load copies to count", d, 2);
            apb_wr(5'h08, 32'hC0 | (c << 2), t0);
            while (!irq && cyc < t0 + 5000) @(negedge clk);
            t1 = cyc;
            chk($sformatf("R2 R5 R8 period code %0d", c), t1 - t0, 3 * ratio_of(c));
        end
        apb_wr(5'h08, 32'h0, t0);

        // R9: flag is sticky while disabled, then cleared by CLEAR write
        idle(20);
        chk("R9 flag sticky", irq, 1);
        apb_rd(5'h0C, d); chk("R9 status bit", d, 1);
        apb_wr(5'h10, 32'h1, t0);
        chk("R9 cleared", irq, 0);

        // R7: disabled counter holds
        apb_rd(5'h04, d); idle(40); apb_rd(5'h04, d2);
        chk("R7 count held while disabled", d2, d);
        chk("R7 no flag while disabled", irq, 0);

        // R4: free-running wraps to 0xFFFF without interrupt
        apb_wr(5'h00, 32'd3, t0);
        apb_wr(5'h08, 32'h80, t0);
        idle(8);
        apb_wr(5'h08, 32'h0, t0);
        apb_rd(5'h04, d);
        chk("R4 wrapped high", d > 32'hFF00, 1);
        chk("R4 no irq in free mode", irq, 0);

        // R6: load write while enabled does not touch the count
        apb_wr(5'h00, 32'd100, t0);
        apb_wr(5'h08, 32'hDC, t0);
        apb_wr(5'h00, 32'd5, t0);
        apb_rd(5'h04, d); chk("R6 enabled load keeps count", d, 100);
        apb_rd(5'h00, d); chk("R6 load reg updated", d, 5);
        apb_wr(5'h08, 32'h0, t0);

        // R3: count decrements at /16
        apb_wr(5'h00, 32'd50, t0);
        apb_wr(5'h08, 32'h84, t0);
        idle(100);
        apb_wr(5'h08, 32'h0, t0);
        apb_rd(5'h04, d);
        chk("R3 count decreased", (d < 50) && (d > 40), 1);

        // R11: load 0 periodic, flag every tick; set wins over clear
        apb_wr(5'h10, 32'h1, t0);
        apb_wr(5'h00, 32'd0, t0);
        apb_wr(5'h08, 32'hC0, t0);
        while (!irq && cyc < t0 + 100) @(negedge clk);
        chk("R11 first tick interrupt", cyc - t0, 1);
        apb_wr(5'h10, 32'h1, t0);
        chk("R11 R9 set wins over clear", irq, 1);
        apb_wr(5'h08, 32'h0, t0);
        apb_wr(5'h10, 32'h1, t0);
        chk("R9 clear after disable", irq, 0);

        idle(5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        done = 1;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule